// File: doc/BRIEF.md
# Character LCD Row-Column Text Writer

This block sits on the host side of a character display that is 20 columns wide and 4 rows tall. It takes a stream of input items. Each item is a printable character, a newline, a clear-screen request or a jump to a given row and column. The block turns these items into a stream of bytes for a separate bus write engine. Each byte carries a register-select flag: 0 for a command and 1 for display data.

The display controller does not store its rows one after another. Rows 0 and 2 share the low half of the address space, and rows 1 and 3 share the upper half. Streaming bytes past the end of row 0 would therefore land on row 2. The writer keeps track of the logical cursor itself. Whenever the cursor reaches a new row, or is moved by a jump, the writer sends a set-address command before the next character. When the cursor stays on the same row, characters go out back to back with no extra command.

Both sides use a valid/ready handshake. The writer holds one byte at a time, and it stops taking input while that byte is waiting to be taken.

Top module: `lcd_text_writer`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the cursor is at row 0, column 0. The first character after reset is preceded by the command 0x80 (RS=0).
- R2: A set-address command is the byte 0x80 OR'd with the 7-bit display address, sent with RS=0. Column 0 of rows 0, 1, 2 and 3 sits at addresses 0x00, 0x40, 0x14 and 0x54, and the address rises by one per column.
- R3: A character item (`in_kind` = 0) emits `in_char` with RS=1. Further characters on the same row are emitted with no command between them.
- R4: Writing a character in column 19 moves the cursor to column 0 of the next row, and row 3 wraps to row 0. The next character is preceded by the set-address command for the new position.
- R5: A newline item (`in_kind` = 1) emits no byte and moves the cursor to column 0 of the next row, with row 3 wrapping to row 0. The next character is preceded by the set-address command for that position.
- R6: A clear item (`in_kind` = 2) emits the command 0x01 with RS=0 and puts the cursor at row 0, column 0. The next character is then sent with no set-address command.
- R7: A jump item (`in_kind` = 3) emits no byte and moves the cursor to `in_row`/`in_col`. A column above 19 is taken as 19. The next character is preceded by the set-address command for that position.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_rs` and `out_byte` stay unchanged.
- R9: `in_ready` is 0 whenever a byte is waiting on the output, so no input item is taken in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Writer accepts an item this cycle |
| in_kind | input | 2 | 0 character, 1 newline, 2 clear, 3 jump |
| in_char | input | 8 | Character code for a character item |
| in_row | input | 2 | Target row for a jump item |
| in_col | input | 5 | Target column for a jump item |
| out_valid | output | 1 | Byte waiting for the write engine |
| out_ready | input | 1 | Write engine takes the byte |
| out_rs | output | 1 | 0 command byte, 1 data byte |
| out_byte | output | 8 | Command or data byte |

## Verification
The bench targets the corner cases that stress the interleaved row layout:
- A run of 25 characters from the home position must produce a command of 0xC0 after column 19. A design that streams bytes without re-addressing would leave characters on row 2 and never send that command.
- A jump to row 3, column 15 followed by six characters crosses the wrap from row 3 back to row 0. It also checks the computed address 0xE3 and the wrapped address 0x80.
- A jump to column 31 must come out as address 0xA7. A design that does not clamp would emit a command off the end of the row.
- A clear followed by characters must not re-address. A design that marks the position stale after a clear would send a redundant 0x80.
- Output readiness is throttled throughout. This exposes a design that drops or changes a held byte, or that accepts input while a byte is still waiting.

// File: rtl/lcdtw_pkg.sv
package lcdtw_pkg;
   typedef enum logic [1:0] {
      KIND_CHAR    = 2'd0,
      KIND_NEWLINE = 2'd1,
      KIND_CLEAR   = 2'd2,
      KIND_GOTO    = 2'd3
   } kind_e;

   localparam logic [7:0] CMD_CLEAR   = 8'h01;
   localparam logic [7:0] CMD_SETADDR = 8'h80;
   localparam int unsigned ODD_ROW_BASE = 'h40;
endpackage

// File: rtl/lcdtw_addr_map.sv
module lcdtw_addr_map #(
   parameter int unsigned COLS = 20,
   parameter int unsigned ROWS = 4
) (
   input  logic [$clog2(ROWS)-1:0] row,
   input  logic [$clog2(COLS)-1:0] col,
   output logic [6:0]              addr
);
   import lcdtw_pkg::*;

   localparam logic [6:0] ODD_BASE  = 7'(ODD_ROW_BASE);
   localparam logic [6:0] HIGH_BASE = 7'(COLS);

   logic [6:0] base;

   generate
      if (ROWS == 4) begin : g_interleaved
         // rows 2 and 3 follow rows 0 and 1 inside the same address half
         assign base = (row[0] ? ODD_BASE : 7'd0) + (row[1] ? HIGH_BASE : 7'd0);
      end else begin : g_two_row
         assign base = row[0] ? ODD_BASE : 7'd0;
      end
   endgenerate

   assign addr = base + 7'(col);
endmodule

// File: rtl/lcdtw_cursor.sv
module lcdtw_cursor #(
   parameter int unsigned COLS = 20,
   parameter int unsigned ROWS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step,
   input  logic                    newline,
   input  logic                    home,
   input  logic                    jump,
   input  logic [$clog2(ROWS)-1:0] jrow,
   input  logic [$clog2(COLS)-1:0] jcol,
   input  logic                    synced,
   output logic [$clog2(ROWS)-1:0] row,
   output logic [$clog2(COLS)-1:0] col,
   output logic                    stale
);
   localparam int unsigned RW = $clog2(ROWS);
   localparam int unsigned CW = $clog2(COLS);
   localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
   localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

   logic [RW-1:0] next_row;
   logic [CW-1:0] jcol_lim;

   assign next_row = (row == LAST_ROW) ? '0 : row + 1'b1;
   assign jcol_lim = (jcol > LAST_COL) ? LAST_COL : jcol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row   <= '0;
         col   <= '0;
         stale <= 1'b1;
      end else if (home) begin
         row   <= '0;
         col   <= '0;
         stale <= 1'b0;
      end else if (jump) begin
         row   <= jrow;
         col   <= jcol_lim;
         stale <= 1'b1;
      end else if (newline) begin
         row   <= next_row;
         col   <= '0;
         stale <= 1'b1;
      end else begin
         if (synced) stale <= 1'b0;
         if (step) begin
            if (col == LAST_COL) begin
               col   <= '0;
               row   <= next_row;
               stale <= 1'b1;
            end else begin
               col <= col + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/lcdtw_out_slot.sv
module lcdtw_out_slot #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          load_rs,
   input  logic [DW-1:0] load_byte,
   input  logic          ready,
   output logic          valid,
   output logic          rs,
   output logic [DW-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         rs    <= 1'b0;
         data  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         rs    <= load_rs;
         data  <= load_byte;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/lcd_text_writer.sv
module lcd_text_writer #(
   parameter int unsigned COLS = 20,
   parameter int unsigned ROWS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [1:0]              in_kind,
   input  logic [7:0]              in_char,
   input  logic [$clog2(ROWS)-1:0] in_row,
   input  logic [$clog2(COLS)-1:0] in_col,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic                    out_rs,
   output logic [7:0]              out_byte
);
   import lcdtw_pkg::*;

   localparam int unsigned RW = $clog2(ROWS);
   localparam int unsigned CW = $clog2(COLS);

   generate
      if (ROWS != 2 && ROWS != 4) begin : g_bad_rows
         $error("lcd_text_writer: ROWS must be 2 or 4");
      end
      if (COLS < 2 || COLS * ((ROWS + 1) / 2) > ODD_ROW_BASE) begin : g_bad_cols
         $error("lcd_text_writer: COLS does not fit one address half");
      end
   endgenerate

   logic [RW-1:0] cur_row;
   logic [CW-1:0] cur_col;
   logic          cur_stale;
   logic [6:0]    cur_addr;
   logic          hold_q;
   logic [7:0]    hold_char_q;

   logic acc, fire, char_direct, char_cmd, do_clear, from_hold;
   logic load, load_rs;
   logic [7:0] load_byte;

   assign in_ready    = !out_valid;
   assign acc         = in_valid && in_ready;
   assign fire        = out_valid && out_ready;
   assign char_direct = acc && (in_kind == KIND_CHAR) && !cur_stale;
   assign char_cmd    = acc && (in_kind == KIND_CHAR) && cur_stale;
   assign do_clear    = acc && (in_kind == KIND_CLEAR);
   assign from_hold   = fire && hold_q;
   assign load        = char_direct || char_cmd || do_clear || from_hold;

   always_comb begin
      load_rs   = 1'b1;
      load_byte = in_char;
      if (from_hold) begin
         load_byte = hold_char_q;
      end else if (char_cmd) begin
         load_rs   = 1'b0;
         load_byte = CMD_SETADDR | {1'b0, cur_addr};
      end else if (do_clear) begin
         load_rs   = 1'b0;
         load_byte = CMD_CLEAR;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= 1'b0;
         hold_char_q <= '0;
      end else if (char_cmd) begin
         hold_q      <= 1'b1;
         hold_char_q <= in_char;
      end else if (from_hold) begin
         hold_q      <= 1'b0;
      end
   end

   lcdtw_cursor #(.COLS(COLS), .ROWS(ROWS)) u_cursor (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (char_direct || from_hold),
      .newline (acc && (in_kind == KIND_NEWLINE)),
      .home    (do_clear),
      .jump    (acc && (in_kind == KIND_GOTO)),
      .jrow    (in_row),
      .jcol    (in_col),
      .synced  (char_cmd),
      .row     (cur_row),
      .col     (cur_col),
      .stale   (cur_stale)
   );

   lcdtw_addr_map #(.COLS(COLS), .ROWS(ROWS)) u_map (
      .row  (cur_row),
      .col  (cur_col),
      .addr (cur_addr)
   );

   lcdtw_out_slot #(.DW(8)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_rs   (load_rs),
      .load_byte (load_byte),
      .ready     (out_ready),
      .valid     (out_valid),
      .rs        (out_rs),
      .data      (out_byte)
   );
endmodule

// File: rtl/lcd_text_writer_chk.sv
module lcd_text_writer_chk #(
   parameter int unsigned COLS = 20,
   parameter int unsigned ROWS = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ready,
   input logic [1:0] in_kind,
   input logic       out_valid,
   input logic       out_ready,
   input logic       out_rs,
   input logic [7:0] out_byte
);
   localparam int unsigned SPAN = (ROWS > 2) ? 2 * COLS : COLS;

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && in_ready));

   // R2
   cmd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_rs && out_byte != 8'h01) |-> (out_byte[7] && (32'(out_byte[5:0]) < SPAN)));

   // R3
   char_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_kind == 2'd0) |=> out_valid);

   // R5
   newline_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_kind == 2'd1) |=> !out_valid);

   // R6
   clear_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_kind == 2'd2) |=> (out_valid && !out_rs && out_byte == 8'h01));

   // R7
   goto_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_kind == 2'd3) |=> !out_valid);

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_rs)));

   // R9
   busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);
endmodule

bind lcd_text_writer lcd_text_writer_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_kind   (in_kind),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_rs    (out_rs),
   .out_byte  (out_byte)
);

// File: tb/lcd_text_writer_test.sv
`timescale 1ns/1ps
module lcd_text_writer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [1:0] in_kind = 2'd0;
   logic [7:0] in_char = 8'd0;
   logic [1:0] in_row = 2'd0;
   logic [4:0] in_col = 5'd0;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic       out_rs;
   logic [7:0] out_byte;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int ready_mode = 0;

   logic [8:0] exp_q[$];
   string      tag_q[$];

   int    mrow = 0;
   int    mcol = 0;
   bit    mstale = 1'b1;
   string mreason = "R1";

   logic       prev_wait = 1'b0;
   logic [8:0] prev_out = '0;

   always #2.5 clk = ~clk;

   lcd_text_writer uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_kind(in_kind), .in_char(in_char), .in_row(in_row), .in_col(in_col),
      .out_valid(out_valid), .out_ready(out_ready), .out_rs(out_rs), .out_byte(out_byte)
   );

   task automatic report;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 50000) begin
         errors = errors + 1;
         $display("FAIL watchdog expired: actual hung run, expected completion");
         report();
      end
   end

   // row base addresses from R2
   function automatic int row_base(int r);
      case (r)
         0: return 'h00;
         1: return 'h40;
         2: return 'h14;
         default: return 'h54;
      endcase
   endfunction

   // behavioural model: one item in, expected bytes pushed
   task automatic model_item(int kind, int ch, int r, int c, string why);
      case (kind)
         0: begin
            if (mstale) begin
               exp_q.push_back({1'b0, 8'(8'h80 | row_base(mrow) + mcol)});
               tag_q.push_back({mreason, " R2"});
               mstale = 1'b0;
            end
            exp_q.push_back({1'b1, 8'(ch)});
            tag_q.push_back("R3");
            mcol++;
            if (mcol == 20) begin
               mcol = 0; mrow = (mrow + 1) % 4; mstale = 1'b1; mreason = "R4";
            end
         end
         1: begin
            mcol = 0; mrow = (mrow + 1) % 4; mstale = 1'b1; mreason = "R5";
         end
         2: begin
            exp_q.push_back({1'b0, 8'h01});
            tag_q.push_back("R6");
            mrow = 0; mcol = 0; mstale = 1'b0;
         end
         default: begin
            mrow = r; mcol = (c > 19) ? 19 : c; mstale = 1'b1; mreason = why;
         end
      endcase
   endtask

   // called at a negedge; returns at a negedge with in_valid low
   task automatic put(int kind, int ch, int r, int c, string why);
      model_item(kind, ch, r, c, why);
      in_valid = 1'b1;
      in_kind  = 2'(kind);
      in_char  = 8'(ch);
      in_row   = 2'(r);
      in_col   = 5'(c);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic put_text(int first, int n);
      for (int i = 0; i < n; i++) put(0, first + i, 0, 0, "");
   endtask

   task automatic drain;
      for (int i = 0; i < 400; i++) begin
         if (exp_q.size() == 0 && !out_valid) break;
         @(negedge clk);
      end
   endtask

   // output monitor and ready driver, all at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = (cyc % 3) != 0;
            default: out_ready = (cyc % 5) == 4;
         endcase
         // R8: a byte left waiting must not move
         if (prev_wait) begin
            checks++;
            if (!out_valid || {out_rs, out_byte} != prev_out) begin
               errors++;
               $display("FAIL R8 held byte changed: actual v=%0b %h expected v=1 %h",
                        out_valid, {out_rs, out_byte}, prev_out);
            end
         end
         // R9: no input acceptance while a byte waits
         if (out_valid) begin
            checks++;
            if (in_ready) begin
               errors++;
               $display("FAIL R9 in_ready while busy: actual 1 expected 0");
            end
         end
         if (out_valid && out_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R5 R7 unexpected byte: actual %h expected none", {out_rs, out_byte});
            end else begin
               logic [8:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if ({out_rs, out_byte} != e) begin
                  errors++;
                  $display("FAIL %s byte mismatch: actual rs=%0b %h expected rs=%0b %h",
                           t, out_rs, out_byte, e[8], e[7:0]);
               end
            end
         end
         prev_wait = out_valid && !out_ready;
         prev_out  = {out_rs, out_byte};
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         errors++;
         $display("FAIL R1 reset state: actual v=%0b rdy=%0b expected v=0 rdy=1", out_valid, in_ready);
      end

      // R1 R3 R4: 25 characters from home cross into row 1
      put_text(8'h41, 25);
      drain();

      // R4 with throttled ready: row 3 wraps to row 0
      ready_mode = 1;
      put(3, 0, 3, 15, "R7");
      put_text(8'h61, 6);
      drain();

      // R5 newline then text
      put(1, 0, 0, 0, "");
      put_text(8'h30, 3);
      put(1, 0, 0, 0, "");
      put(1, 0, 0, 0, "");
      put_text(8'h35, 2);
      drain();

      // R7 column clamp, then wrap to row 3
      ready_mode = 2;
      put(3, 0, 2, 31, "R7");
      put_text(8'h4B, 3);
      drain();

      // R6 clear, then text without re-addressing
      put(2, 0, 0, 0, "");
      put_text(8'h50, 4);
      drain();

      // R2 start of every row
      ready_mode = 0;
      for (int r = 0; r < 4; r++) begin
         put(3, 0, r, 0, "R2");
         put(0, 8'h2A, 0, 0, "");
         put(3, 0, r, 19, "R2");
         put(0, 8'h2B, 0, 0, "");
      end
      drain();

      // R9 item offered while stalled output
      ready_mode = 2;
      put_text(8'h71, 5);
      put(2, 0, 0, 0, "");
      drain();

      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R3 missing bytes: actual %0d left expected 0", exp_q.size());
      end
      report();
   end
endmodule